// File: doc/BRIEF.md
# Parallel Masked Priority Interrupt Controller

This block collects interrupt requests from four devices and turns them into a single interrupt line and a vector address for the processor. Each device pulses its own request input. That pulse latches a pending bit, and the bit stays set until the processor acknowledges it. Software writes a per-source mask and a global enable through a small write port. A pending bit that is masked is held, but it is not offered to the processor.

A fixed priority encoder looks at the unmasked pending bits and picks the lowest-numbered one. Source 0 has the highest priority. The encoder produces a two-bit code that forms the low bits of an 8-bit vector address; the upper bits are zero. A status flag shows that at least one unmasked request exists, and the interrupt line is that flag gated by the global enable.

While the processor holds the acknowledge input, the block drives the vector onto its output. At the clock edge that ends the acknowledge cycle, it clears only the pending bit of the source being serviced.

Top module: `pic_par_prio`

## Requirements
- R1: After reset all pending bits, the mask and the enable are zero, so int_o, ist_o and vec_o are all 0, even when ack_i is high.
- R2: A high req_i[k] at a clock edge sets pending bit k. The bit stays set, with no further requests, until an acknowledge clears it.
- R3: ist_o is 1 exactly when some pending bit k is set and mask bit k is 1. A mask bit of 1 enables the source.
- R4: The service code is the index of the lowest-numbered unmasked pending source. The codes are 0 (source 0), 1 (source 1), 2 (source 2) and 3 (source 3 alone).
- R5: int_o equals ist_o AND the global enable bit.
- R6: vec_o is {6'b000000, code} while ack_i is 1 and ist_o is 1. In every other case vec_o is zero.
- R7: An acknowledge at a clock edge with ist_o=1 clears the pending bit of the coded source only. All other pending bits are kept.
- R8: When a request and an acknowledge clear hit the same pending bit in the same cycle, the bit stays set.
- R9: A clock edge with wr_en_i=1 loads wr_mask_i into the mask and wr_ien_i into the enable. With wr_en_i=0 both keep their values.
- R10: Masking does not drop a request. A pending bit that is masked shows up in ist_o as soon as its mask bit is written to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Per-source request pulses |
| wr_en_i | input | 1 | Write strobe for the mask and the enable |
| wr_mask_i | input | 4 | New mask value; 1 enables a source |
| wr_ien_i | input | 1 | New global enable value |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| int_o | output | 1 | Interrupt request to the processor |
| ist_o | output | 1 | An unmasked request is pending |
| vec_o | output | 8 | Vector address, valid during acknowledge |

## Verification
Two events can land on the same pending bit in one cycle: a new device request and the clear caused by acknowledging that same source. The bench provokes this by raising the request for the source currently being served while ack_i is high. It then judges the outcome at the ports: after that edge, ist_o must still be 1 and the next acknowledge must return the same vector. A second pairing is a mask write in the same cycle as a pending request. The bench judges it by whether ist_o appears in the cycle after the write.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PIC_NUM_SRC = 4;
  localparam int unsigned PIC_VEC_W   = 8;

  function automatic int unsigned pic_idx_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pic_pend_reg.sv
module pic_pend_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // set dominates clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pic_ctrl_reg.sv
module pic_ctrl_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [N-1:0] wr_mask_i,
  input  logic         wr_ien_i,
  output logic [N-1:0] mask_o,
  output logic         ien_o
);
  logic [N-1:0] mask_q;
  logic         ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      ien_q  <= 1'b0;
    end else if (wr_en_i) begin
      mask_q <= wr_mask_i;
      ien_q  <= wr_ien_i;
    end
  end

  assign mask_o = mask_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] code_o,
  output logic             any_o
);
  assign any_o = |req_i;

  if (N == 4 && IDX_W == 2) begin : g_four
    logic x, y;
    assign x = ~req_i[0] & ~req_i[1];
    assign y = (~req_i[0] & req_i[1]) | (~req_i[0] & ~req_i[2]);
    assign code_o = {x, y};
  end else begin : g_generic
    always_comb begin
      code_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (req_i[i]) code_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pic_par_prio.sv
module pic_par_prio
  import pic_pkg::*;
#(
  parameter int unsigned N     = PIC_NUM_SRC,
  parameter int unsigned VEC_W = PIC_VEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             wr_en_i,
  input  logic [N-1:0]     wr_mask_i,
  input  logic             wr_ien_i,
  input  logic             ack_i,
  output logic             int_o,
  output logic             ist_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int unsigned IDX_W = pic_idx_w(N);

  logic [N-1:0]     pend_q;
  logic [N-1:0]     mask_q;
  logic             ien_q;
  logic [N-1:0]     masked;
  logic [N-1:0]     clr;
  logic [IDX_W-1:0] code;
  logic             any;

  pic_ctrl_reg #(.N(N)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_mask_i (wr_mask_i),
    .wr_ien_i  (wr_ien_i),
    .mask_o    (mask_q),
    .ien_o     (ien_q)
  );

  pic_pend_reg #(.N(N)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend_q)
  );

  assign masked = pend_q & mask_q;

  pic_prio_enc #(.N(N), .IDX_W(IDX_W)) u_enc (
    .req_i  (masked),
    .code_o (code),
    .any_o  (any)
  );

  for (genvar k = 0; k < N; k++) begin : g_clr
    assign clr[k] = ack_i & any & (code == IDX_W'(k));
  end

  assign ist_o = any;
  assign int_o = any & ien_q;
  assign vec_o = (ack_i && any) ? {{(VEC_W-IDX_W){1'b0}}, code} : '0;
endmodule

// File: rtl/pic_par_prio_chk.sv
module pic_par_prio_chk #(
  parameter int unsigned N     = 4,
  parameter int unsigned VEC_W = 8,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N-1:0]     req_i,
  input logic             wr_en_i,
  input logic             ack_i,
  input logic             int_o,
  input logic             ist_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [N-1:0]     pend_q,
  input logic [N-1:0]     mask_q,
  input logic             ien_q
);
  logic [N-1:0] sel_low;
  always_comb begin
    sel_low = '0;
    for (int i = 0; i < N; i++)
      if (i < int'(vec_o[IDX_W-1:0])) sel_low[i] = 1'b1;
  end

  a_r3_ist_tracks_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ist_o == |(pend_q & mask_q));

  a_r5_int_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (ien_q && ist_o));

  a_r6_vec_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && ist_o) |-> vec_o == '0);

  a_r6_vec_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o[VEC_W-1:IDX_W] == '0);

  a_r4_vec_is_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ist_o) |-> (pend_q[vec_o[IDX_W-1:0]] && mask_q[vec_o[IDX_W-1:0]]
                          && ((pend_q & mask_q & sel_low) == '0)));

  a_r8_request_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> ((pend_q & $past(req_i)) == $past(req_i)));

  a_r7_ack_clears_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ist_o && !req_i[vec_o[IDX_W-1:0]]) |=> !pend_q[$past(vec_o[IDX_W-1:0])]);

  a_r9_mask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(mask_q) && $stable(ien_q)));
endmodule

bind pic_par_prio pic_par_prio_chk #(.N(N), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .wr_en_i (wr_en_i),
  .ack_i   (ack_i),
  .int_o   (int_o),
  .ist_o   (ist_o),
  .vec_o   (vec_o),
  .pend_q  (pend_q),
  .mask_q  (mask_q),
  .ien_q   (ien_q)
);

// File: tb/tb_pic_par_prio.sv
`timescale 1ns/1ps
module tb_pic_par_prio;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_mask_i = '0;
  logic       wr_ien_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       int_o, ist_o;
  logic [7:0] vec_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m_pend = '0, m_mask = '0;
  logic       m_ien = 1'b0;

  always #5 clk_i = ~clk_i;

  pic_par_prio dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_en_i(wr_en_i),
    .wr_mask_i(wr_mask_i), .wr_ien_i(wr_ien_i), .ack_i(ack_i),
    .int_o(int_o), .ist_o(ist_o), .vec_o(vec_o)
  );

  function automatic int top_idx(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic cmp(input string tag, input string sig, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, sig, act, exp);
    end
  endtask

  // apply inputs, check outputs, then advance one clock and the model
  task automatic step(input string tag, input logic [3:0] req, input logic wr,
                      input logic [3:0] msk, input logic ien, input logic ack);
    logic [3:0] mk;
    int e_vec;
    req_i = req; wr_en_i = wr; wr_mask_i = msk; wr_ien_i = ien; ack_i = ack;
    #1;
    mk = m_pend & m_mask;
    e_vec = (ack && mk != 0) ? top_idx(mk) : 0;
    cmp({tag, "/R3"}, "ist_o", int'(ist_o), int'(mk != 0));
    cmp({tag, "/R5"}, "int_o", int'(int_o), int'((mk != 0) && m_ien));
    cmp({tag, "/R6"}, "vec_o", int'(vec_o), e_vec);
    @(posedge clk_i);
    if (ack && mk != 0) m_pend[top_idx(mk)] = 1'b0;
    m_pend = m_pend | req;
    if (wr) begin m_mask = msk; m_ien = ien; end
    @(negedge clk_i);
    req_i = '0; wr_en_i = 1'b0; ack_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state, acknowledge high gives nothing
    step("R1", 4'h0, 1'b0, 4'h0, 1'b0, 1'b1);
    // R9: no write strobe, mask must stay zero
    step("R9", 4'hF, 1'b0, 4'hF, 1'b1, 1'b0);
    step("R9", 4'h0, 1'b0, 4'h0, 1'b0, 1'b0);
    // R10: masked pending appears once unmasked
    step("R10", 4'h0, 1'b1, 4'h8, 1'b1, 1'b0);
    step("R10", 4'h0, 1'b1, 4'hF, 1'b1, 1'b0);
    // R7 and R4: drain in priority order, others held
    for (int k = 0; k < 4; k++) step("R7", 4'h0, 1'b0, 4'h0, 1'b0, 1'b1);
    step("R7", 4'h0, 1'b0, 4'h0, 1'b0, 1'b0);
    // R2: single pulse holds
    step("R2", 4'h4, 1'b0, 4'h0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) step("R2", 4'h0, 1'b0, 4'h0, 1'b0, 1'b0);
    // R8: request on the bit being served, set wins
    step("R8", 4'h4, 1'b0, 4'h0, 1'b0, 1'b1);
    step("R8", 4'h0, 1'b0, 4'h0, 1'b0, 1'b1);
    step("R8", 4'h0, 1'b0, 4'h0, 1'b0, 1'b0);
    // R4: full sweep of mask, enable and request patterns
    for (int m = 0; m < 16; m++)
      for (int e = 0; e < 2; e++)
        for (int p = 0; p < 16; p++) begin
          step("R9", 4'h0, 1'b1, 4'(m), 1'(e), 1'b0);
          step("R2", 4'(p), 1'b0, 4'h0, 1'b0, 1'b0);
          step("R4", 4'h0, 1'b0, 4'h0, 1'b0, 1'b1);
          step("R7", 4'h0, 1'b0, 4'h0, 1'b0, 1'b0);
          step("R10", 4'h0, 1'b1, 4'hF, 1'(e), 1'b0);
          for (int k = 0; k < 4; k++) step("R7", 4'h0, 1'b0, 4'h0, 1'b0, 1'b1);
        end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule